// File: doc/BRIEF.md
# Compare Match Timer Channel Group

This block holds several independent timer channels behind one small register bus. Every channel owns an up-counter, a compare register and a 16-bit control/status word. A clock prescaler turns the system clock into a slower counting clock. When a counting tick finds the counter equal to its compare value, the counter returns to zero, a status flag is raised and, if enabled, the channel's interrupt line is driven high. The channel therefore fires once every compare+1 counting ticks.

Software starts and stops channels through one shared run register, in which each channel has its own bit. It acknowledges a match by writing the flag back as zero. A counter write does not take effect at once. It is held in a pending stage and lands on the second counting tick after the write, which models a slow, separately clocked counter. A parameter selects one of two variants. The wide variant has 32-bit counters, a divide-by-8 prescaler and two status flags. The narrow variant has 16-bit counters, a divide-by-512 prescaler and one status flag.

Top module: `cmt_group`

## Requirements
- R1: After reset, the run register and every control/status word read 0, every counter reads 0, every compare register reads all ones (0xFFFFFFFF wide, 0xFFFF narrow), and all interrupt lines are low.
- R2: The run register sits at byte address 0x00. Channel n occupies the block starting at 16*(n+1). Within a block, word 0 is control/status, word 1 is the counter and word 2 is the compare register. The byte offset of a word is its index times 4 in the wide variant and times 2 in the narrow one. Read data appears on `bus_rdata` in the cycle after the read and holds until the next read.
- R3: Bit n of the run register enables channel n. While the bit is set, the counter advances once per counting tick. While it is clear, the counter holds its value.
- R4: On a counting tick where the counter equals the compare value, the counter becomes 0 and the match flag is set. The match flag is bit 15 in the wide variant and bit 7 in the narrow one. The match period is therefore (compare+1) ticks.
- R5: A compare write while the counter runs applies to the next equality check.
- R6: After a counter write, reads keep returning the old value. The new value is loaded on the second counting tick after the write, so it is visible within 2 ticks plus one clock.
- R7: Writing 0 to a status flag clears it. Writing 1 leaves it unchanged and never sets it. A match in the same cycle as a clearing write leaves the flag set.
- R8: In the wide variant, bit 14 is an overrun flag. It is set when a match occurs while the match flag is still set, and it clears like any other status flag.
- R9: A channel's interrupt is high exactly when its match flag and its enable bit (bit 6) are both 1. Writing 0 to control/status drops the interrupt on the next cycle.
- R10: The counting tick comes every 8 clocks in the wide variant and every 512 clocks in the narrow one.
- R11: Channels are independent. Running or stopping one channel leaves the other channels' counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access strobe, one cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | NUM_CH | Per-channel interrupt request |

## Verification
The bench goes after the delayed counter load, reading straight after the write. A design that loaded at once would return the new value too early, and one that lost the pending value would never return it. It measures the exact spacing between successive interrupt edges, which exposes an off-by-one period, that is a wrap at compare instead of compare+1. It writes ones over set and cleared flags and zeros around matches, which catches flags that software could set, or that a single write could not clear. It also moves the compare value below its old setting while the counter runs, which catches a compare value that is latched only at the wrap.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  localparam int CSR_W   = 16;
  localparam int IE_BIT  = 6;
  localparam int OVR_BIT = 14;

  typedef enum logic [1:0] {
    IDX_CSR  = 2'd0,
    IDX_CNT  = 2'd1,
    IDX_CMP  = 2'd2,
    IDX_NONE = 2'd3
  } reg_idx_e;

  // counting clock divisor per counter width
  function automatic int presc_div(input int cnt_w);
    return (cnt_w == 16) ? 512 : 8;
  endfunction

  // position of the match flag
  function automatic int flag_bit(input int cnt_w);
    return (cnt_w == 16) ? 7 : 15;
  endfunction

  // log2 of the byte stride between registers of a channel
  function automatic int addr_shift(input int cnt_w);
    return (cnt_w == 16) ? 1 : 2;
  endfunction

  // status bits that are cleared by writing zero
  function automatic logic [CSR_W-1:0] status_mask(input int cnt_w);
    return (cnt_w == 16) ? 16'h0080 : 16'hC000;
  endfunction

  // plain bits take the written value, status bits may only fall
  function automatic logic [CSR_W-1:0] csr_merge(input logic [CSR_W-1:0] old_v,
                                                 input logic [CSR_W-1:0] wr_v,
                                                 input logic [CSR_W-1:0] smask);
    return (wr_v & ~smask) | (old_v & wr_v & smask);
  endfunction

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n)             phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + 1'b1;
  end

  assign tick = (phase == LAST);

  generate
    if (DIV > 1) begin : g_gap
      AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R10
    end
  endgenerate

endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic [CNT_W-1:0] cmp,
  input  logic             ld_req,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt,
  output logic             match_evt,
  output logic             load_evt
);
  logic [1:0]       stage;
  logic [CNT_W-1:0] pend;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] cur,
                                            input logic hit);
    return hit ? '0 : cur + 1'b1;
  endfunction

  assign load_evt  = tick && (stage == 2'd1);
  assign match_evt = tick && run && !load_evt && (cnt == cmp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      stage <= 2'd0;
      pend  <= '0;
    end else begin
      if (load_evt)         cnt <= pend;
      else if (tick && run) cnt <= step(cnt, match_evt);
      if (ld_req) begin
        pend  <= ld_val;
        stage <= 2'd2;
      end else if (tick && stage != 2'd0) begin
        stage <= stage - 2'd1;
      end
    end
  end

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> cnt == '0); // R4
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_evt) |=> $stable(cnt)); // R3
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> cnt == $past(pend)); // R6
  AST_NO_EARLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req |=> !load_evt); // R6

endmodule

// File: rtl/cmt_csr.sv
module cmt_csr
  import cmt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CSR_W-1:0] wdata,
  input  logic             match_evt,
  output logic [CSR_W-1:0] csr,
  output logic             irq
);
  localparam int              FB      = flag_bit(CNT_W);
  localparam logic [CSR_W-1:0] SMASK  = status_mask(CNT_W);
  localparam bit              HAS_OVR = (CNT_W != 16);

  logic [CSR_W-1:0] base_v;
  logic [CSR_W-1:0] csr_n;

  always_comb begin
    base_v = wr ? csr_merge(csr, wdata, SMASK) : csr;
    csr_n  = base_v;
    if (match_evt) begin
      csr_n[FB] = 1'b1;
      if (HAS_OVR && base_v[FB]) csr_n[OVR_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) csr <= '0;
    else        csr <= csr_n;
  end

  assign irq = csr[FB] & csr[IE_BIT];

  AST_MATCH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> csr[FB]); // R7
  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csr[FB]) |-> $past(match_evt)); // R7
  AST_ZERO_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata == '0) |=> !irq); // R9

  generate
    if (HAS_OVR) begin : g_ovr
      AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && csr[FB] && !wr) |=> csr[OVR_BIT]); // R8
    end
  endgenerate

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wr_csr,
  input  logic             wr_cnt,
  input  logic             wr_cmp,
  input  logic [31:0]      wdata,
  output logic [CSR_W-1:0] csr_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic             irq
);
  localparam int DIV = presc_div(CNT_W);

  logic tick;
  logic match_evt;
  logic load_evt;

  cmt_prescaler #(.DIV(DIV)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      cmp_q <= '1;
    else if (wr_cmp) cmp_q <= wdata[CNT_W-1:0];
  end

  cmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .run      (run),
    .cmp      (cmp_q),
    .ld_req   (wr_cnt),
    .ld_val   (wdata[CNT_W-1:0]),
    .cnt      (cnt_q),
    .match_evt(match_evt),
    .load_evt (load_evt)
  );

  cmt_csr #(.CNT_W(CNT_W)) u_csr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (wr_csr),
    .wdata    (wdata[CSR_W-1:0]),
    .match_evt(match_evt),
    .csr      (csr_q),
    .irq      (irq)
  );

  AST_CMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmp |=> cmp_q == $past(wdata[CNT_W-1:0])); // R5

endmodule

// File: rtl/cmt_group.sv
module cmt_group
  import cmt_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int SH    = addr_shift(CNT_W);
  localparam int BLK_W = ADDR_W - 4;
  localparam logic [3:0] ALIGN_MASK = 4'((1 << SH) - 1);

  logic [BLK_W-1:0]  blk;
  logic [3:0]        word;
  logic              in_blk;
  reg_idx_e          idx;
  logic              glob_hit;
  logic              glob_wr;
  logic [NUM_CH-1:0] run_q;
  logic [NUM_CH-1:0] chan_hit;

  logic [CSR_W-1:0] csr_a [NUM_CH];
  logic [CNT_W-1:0] cnt_a [NUM_CH];
  logic [CNT_W-1:0] cmp_a [NUM_CH];

  assign blk      = bus_addr[ADDR_W-1:4];
  assign word     = bus_addr[3:0] >> SH;
  assign in_blk   = ((bus_addr[3:0] & ALIGN_MASK) == 4'd0) && (word < 4'd3);
  assign idx      = in_blk ? reg_idx_e'(word[1:0]) : IDX_NONE;
  assign glob_hit = (blk == '0) && (bus_addr[3:0] == 4'd0);
  assign glob_wr  = bus_valid && bus_write && glob_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)       run_q <= '0;
    else if (glob_wr) run_q <= bus_wdata[NUM_CH-1:0];
  end

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic sel_wr;
      assign chan_hit[c] = (blk == BLK_W'(c + 1));
      assign sel_wr      = bus_valid && bus_write && chan_hit[c];

      cmt_channel #(.CNT_W(CNT_W)) u_chan (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_q[c]),
        .wr_csr(sel_wr && idx == IDX_CSR),
        .wr_cnt(sel_wr && idx == IDX_CNT),
        .wr_cmp(sel_wr && idx == IDX_CMP),
        .wdata (bus_wdata),
        .csr_q (csr_a[c]),
        .cnt_q (cnt_a[c]),
        .cmp_q (cmp_a[c]),
        .irq   (irq[c])
      );
    end
  endgenerate

  logic [31:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (glob_hit) rd_val[NUM_CH-1:0] = run_q;
    for (int c = 0; c < NUM_CH; c++) begin
      if (chan_hit[c]) begin
        case (idx)
          IDX_CSR: rd_val = {{(32-CSR_W){1'b0}}, csr_a[c]};
          IDX_CNT: rd_val = 32'(cnt_a[c]);
          IDX_CMP: rd_val = 32'(cmp_a[c]);
          default: rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       bus_rdata <= '0;
    else if (bus_valid && !bus_write) bus_rdata <= rd_val;
  end

  AST_RUN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    glob_wr |=> run_q == $past(bus_wdata[NUM_CH-1:0])); // R3
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> $stable(bus_rdata)); // R2

endmodule

// File: tb/cmt_group_tb.sv
module cmt_group_tb;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic        wv = 0, ww = 0;
  logic [7:0]  wa = 0;
  logic [31:0] wd = 0;
  logic [31:0] wrd;
  logic [2:0]  wirq;

  logic        nv = 0, nw = 0;
  logic [7:0]  na = 0;
  logic [31:0] nd = 0;
  logic [31:0] nrd;
  logic [0:0]  nirq;

  cmt_group #(.NUM_CH(3), .CNT_W(32), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(wv), .bus_write(ww), .bus_addr(wa),
    .bus_wdata(wd), .bus_rdata(wrd), .irq(wirq));

  cmt_group #(.NUM_CH(1), .CNT_W(16), .ADDR_W(8)) u_dut_narrow (
    .clk(clk), .rst_n(rst_n), .bus_valid(nv), .bus_write(nw), .bus_addr(na),
    .bus_wdata(nd), .bus_rdata(nrd), .irq(nirq));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard queues
  logic [31:0] q_exp[$];
  logic [31:0] q_msk[$];
  bit          q_nar[$];
  string       q_tag[$];
  bit          sb_pend = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit nar, input bit wr_en, input logic [7:0] a,
                       input logic [31:0] d);
    if (nar) begin nv = 1; nw = wr_en; na = a; nd = d; end
    else     begin wv = 1; ww = wr_en; wa = a; wd = d; end
  endtask

  task automatic idle_bus();
    wv = 0; ww = 0; nv = 0; nw = 0;
  endtask

  task automatic bus_wr(input bit nar, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); drive(nar, 1'b1, a, d);
    @(posedge clk); #1; idle_bus();
  endtask

  task automatic bus_rd(input bit nar, input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); drive(nar, 1'b0, a, 32'h0);
    @(posedge clk); #1; v = nar ? nrd : wrd; idle_bus();
  endtask

  // driver: push expectation, monitor compares when data returns
  task automatic rd_exp(input bit nar, input logic [7:0] a, input logic [31:0] e,
                        input logic [31:0] m, input string tag);
    @(negedge clk); drive(nar, 1'b0, a, 32'h0);
    q_exp.push_back(e); q_msk.push_back(m); q_nar.push_back(nar); q_tag.push_back(tag);
    sb_pend = 1;
    @(posedge clk); #1; idle_bus();
  endtask

  always @(posedge clk) begin
    #2;
    if (sb_pend) begin
      logic [31:0] e, m, act;
      bit nar;
      string tag;
      sb_pend = 0;
      if (q_exp.size() == 0) begin
        chk(1'b0, "scoreboard empty", 32'h0, 32'h0);
      end else begin
        e = q_exp.pop_front(); m = q_msk.pop_front();
        nar = q_nar.pop_front(); tag = q_tag.pop_front();
        act = nar ? nrd : wrd;
        chk(((act ^ e) & m) == 32'h0, tag, act & m, e & m);
      end
    end
  end

  // interrupt rise monitor for channel 0
  int rise_n = 0, last_rise = 0, prev_rise = 0;
  bit irq0_prev = 0;
  always @(posedge clk) begin
    #3;
    if (wirq[0] && !irq0_prev) begin
      rise_n++; prev_rise = last_rise; last_rise = cyc;
    end
    irq0_prev = wirq[0];
  end

  task automatic wait_rise(input int lim, output bit ok);
    int s = rise_n;
    ok = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (rise_n > s) begin ok = 1; break; end
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a, b, v0;
    bit ok;
    int t0;
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1 reset state, R2 address map
    rd_exp(0, 8'h00, 32'h0, 32'hFFFFFFFF, "R1 run reg");
    rd_exp(0, 8'h10, 32'h0, 32'hFFFFFFFF, "R1 ch0 csr");
    rd_exp(0, 8'h14, 32'h0, 32'hFFFFFFFF, "R1 ch0 cnt");
    rd_exp(0, 8'h18, 32'hFFFFFFFF, 32'hFFFFFFFF, "R1 R2 ch0 cmp");
    rd_exp(0, 8'h38, 32'hFFFFFFFF, 32'hFFFFFFFF, "R1 R2 ch2 cmp");
    rd_exp(1, 8'h14, 32'h0000FFFF, 32'hFFFFFFFF, "R1 R2 narrow cmp");
    chk(wirq == 3'b000 && nirq == 1'b0, "R1 irq low", {28'h0, nirq, wirq}, 32'h0);

    // R3 R10 run ch1, 80 clocks = 10 ticks
    bus_wr(0, 8'h00, 32'h2);
    rd_exp(0, 8'h00, 32'h2, 32'hFFFFFFFF, "R3 run readback");
    bus_rd(0, 8'h24, a);
    repeat (79) @(negedge clk);
    bus_rd(0, 8'h24, b);
    chk(b - a == 32'd10, "R3 R10 wide tick rate", b - a, 32'd10);
    rd_exp(0, 8'h14, 32'h0, 32'hFFFFFFFF, "R11 ch0 untouched");
    rd_exp(0, 8'h34, 32'h0, 32'hFFFFFFFF, "R11 ch2 untouched");
    bus_wr(0, 8'h00, 32'h0);
    bus_rd(0, 8'h24, a);
    repeat (40) @(negedge clk);
    bus_rd(0, 8'h24, b);
    chk(a == b, "R3 stopped holds", b, a);

    // R10 narrow prescaler
    bus_wr(1, 8'h00, 32'h1);
    bus_rd(1, 8'h12, a);
    repeat (1023) @(negedge clk);
    bus_rd(1, 8'h12, b);
    chk(b - a == 32'd2, "R10 narrow tick rate", b - a, 32'd2);
    bus_wr(1, 8'h00, 32'h0);
    bus_rd(1, 8'h12, a);
    bus_wr(1, 8'h14, a + 32'd1);
    bus_wr(1, 8'h00, 32'h1);
    repeat (1100) @(negedge clk);
    rd_exp(1, 8'h10, 32'h80, 32'hFFFFFFFF, "R4 narrow flag bit7");
    chk(nirq == 1'b0, "R9 narrow no irq without enable", {31'h0, nirq}, 32'h0);
    bus_wr(1, 8'h00, 32'h0);

    // R4 period on ch0 with compare 3
    bus_wr(0, 8'h18, 32'd3);
    bus_wr(0, 8'h10, 32'h40);
    bus_wr(0, 8'h00, 32'h1);
    wait_rise(200, ok);
    chk(ok, "R4 first match", {31'h0, ok}, 32'h1);
    rd_exp(0, 8'h10, 32'h8040, 32'hFFFFFFFF, "R4 flag set");
    bus_wr(0, 8'h10, 32'h40);
    chk(wirq[0] == 1'b0, "R7 zero write clears", {31'h0, wirq[0]}, 32'h0);
    wait_rise(100, ok);
    bus_wr(0, 8'h10, 32'h40);
    wait_rise(100, ok);
    chk(ok && (last_rise - prev_rise) == 32, "R4 period (cmp+1)*8",
        32'(last_rise - prev_rise), 32'd32);
    for (int i = 0; i < 3; i++) begin
      bus_rd(0, 8'h14, a);
      chk(a <= 32'd3, "R4 counter wraps at compare", a, 32'd3);
    end

    // R8 overrun, R7 write-one has no effect
    repeat (40) @(negedge clk);
    rd_exp(0, 8'h10, 32'hC040, 32'hFFFFFFFF, "R8 overrun set");
    bus_wr(0, 8'h10, 32'hC040);
    rd_exp(0, 8'h10, 32'hC000, 32'hC000, "R7 write one keeps flags");
    chk(wirq[0] == 1'b1, "R9 irq with flag and enable", {31'h0, wirq[0]}, 32'h1);
    bus_wr(0, 8'h10, 32'h40);
    rd_exp(0, 8'h10, 32'h0, 32'h4000, "R8 overrun cleared");

    // R9 zero write disables interrupt
    wait_rise(100, ok);
    bus_wr(0, 8'h10, 32'h0);
    chk(wirq[0] == 1'b0, "R9 zero write drops irq", {31'h0, wirq[0]}, 32'h0);
    repeat (40) @(negedge clk);
    rd_exp(0, 8'h10, 32'h8000, 32'h80C0, "R9 flag set enable off");
    chk(wirq[0] == 1'b0, "R9 no irq when disabled", {31'h0, wirq[0]}, 32'h0);
    bus_wr(0, 8'h00, 32'h0);
    bus_wr(0, 8'h10, 32'h0);
    bus_wr(0, 8'h10, 32'hC000);
    rd_exp(0, 8'h10, 32'h0, 32'hFFFFFFFF, "R7 write one never sets");

    // R5 compare lowered while running
    bus_wr(0, 8'h38, 32'd200);
    bus_wr(0, 8'h00, 32'h4);
    repeat (10) @(negedge clk);
    bus_wr(0, 8'h38, 32'd6);
    t0 = cyc;
    ok = 0;
    for (int i = 0; i < 200; i++) begin
      bus_rd(0, 8'h30, a);
      if (a[15]) begin ok = 1; break; end
    end
    chk(ok && (cyc - t0) <= 80, "R5 new compare used", 32'(cyc - t0), 32'd80);
    bus_rd(0, 8'h34, a);
    chk(a <= 32'd6, "R5 counter under new compare", a, 32'd6);

    // R6 delayed counter write
    bus_wr(0, 8'h00, 32'h0);
    bus_rd(0, 8'h34, v0);
    bus_wr(0, 8'h34, 32'd100);
    t0 = cyc;
    bus_rd(0, 8'h34, a);
    chk(a == v0, "R6 old value right after write", a, v0);
    ok = 0;
    for (int i = 0; i < 30; i++) begin
      bus_rd(0, 8'h34, a);
      if (a == 32'd100) begin ok = 1; break; end
    end
    chk(ok && (cyc - t0) <= 18, "R6 new value within two ticks", 32'(cyc - t0), 32'd18);
    chk(ok && (cyc - t0) >= 9, "R6 not before second tick", 32'(cyc - t0), 32'd9);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule